// File: doc/BRIEF.md
# Carry/Zero Flag Logic Unit

This execute-stage unit belongs to a 32-bit microcontroller core. It holds the carry flag C and the zero flag Z. Each instruction carries a 4-bit condition. The unit evaluates that condition against the current flags. When the condition is true, the unit runs one of three kinds of operation:

- **Flag rewrite.** Each flag can be set to any Boolean function of the old C and Z.
- **Clamp.** The destination is forced to be less-or-equal, or greater-or-equal, to the source, with unsigned or signed comparison.
- **Single-bit edit.** One bit of the destination is cleared, set or inverted.

The condition and the flag rewrite share the same 4-bit truth-table code. A bit edit that is gated on the carry condition therefore behaves as an AND, OR or XOR of a register bit with C.

The surrounding core supplies:

- a valid strobe and the instruction word;
- the destination operand D and the source operand S;
- the carry and zero write enables.

The outputs are registered with one cycle of latency: a result, a result-write strobe, and the flags. An instruction issued on the next cycle sees the updated flags.

Top module: `flagunit`

## Requirements
- R1: While reset is active and after it is released, out_c, out_z, out_wr are 0 and out_result is 0 until the first executed instruction.
- R2: The condition code is instr[31:28]. It is true when bit index {C,Z} of the code is 1. When it is false, or in_valid is 0, out_wr is 0 on the next cycle and both flags keep their value. Every effect of an instruction appears one cycle after it is presented.
- R3: The flag rewrite has opcode instr[27:21]=7'h12, instr[20:17]=0, the C code in instr[16:13], the Z code in instr[12:9] and the sub-opcode instr[8:0]=9'b001101111. A word with any other value in those fixed fields changes nothing.
- R4: A 4-bit function code yields its bit at index {C,Z}. So 0000→0, 1111→1, 1100→C, 1010→Z, 0001→!C&!Z, 0110→C^Z, 1001→C==Z and 1110→C|Z.
- R5: C is written only when in_wc is 1 and Z is written only when in_wz is 1. Otherwise each flag keeps its value, whatever its code.
- R6: Both new flag values are computed from the flags as they were before the instruction.
- R7: Force-less-or-equal (opcode 7'h20 unsigned, 7'h21 signed) writes S when D>S and writes D otherwise.
- R8: Force-greater-or-equal (opcode 7'h22 unsigned, 7'h23 signed) writes S when D<S and writes D otherwise. The signed forms compare in two's complement.
- R9: For the clamps, C (when enabled) becomes 1 exactly when S replaced D. Z (when enabled) becomes 1 exactly when the written result is zero.
- R10: Bit clear, set and invert (opcodes 7'h30, 7'h31, 7'h32) write D with the bit at index S[4:0] changed. The upper bits of S are ignored.
- R11: The bit operations never change C or Z, even with the enables set.
- R12: The flag rewrite and unknown opcodes never assert out_wr. The result register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 32 | Instruction word |
| in_d | input | 32 | Destination operand |
| in_s | input | 32 | Source operand |
| in_wc | input | 1 | Carry write enable |
| in_wz | input | 1 | Zero write enable |
| out_result | output | 32 | Last written result |
| out_wr | output | 1 | Result-write strobe |
| out_c | output | 1 | Carry flag |
| out_z | output | 1 | Zero flag |

## Verification
The condition gate and the operation itself act in the same cycle, and both read the same old flags. The bench provokes this by running carry-gated bit edits and flag rewrites straight after instructions that have just changed C. Each case is judged against a reference model that steps on the flags it predicted for the previous cycle.

The flag rewrite must update C and Z together from their pre-instruction values. Every function-code pair is swept from each of the four starting flag states. The bench compares the outcome with the model on every clock, so any sequential mix-up between the two flags shows at once.

// File: rtl/flagunit_pkg.sv
package flagunit_pkg;
  localparam int unsigned OP_W   = 7;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SUB_W  = 9;

  localparam logic [OP_W-1:0] OP_FMOD = 7'h12;
  localparam logic [OP_W-1:0] OP_FLEU = 7'h20;
  localparam logic [OP_W-1:0] OP_FLES = 7'h21;
  localparam logic [OP_W-1:0] OP_FGEU = 7'h22;
  localparam logic [OP_W-1:0] OP_FGES = 7'h23;
  localparam logic [OP_W-1:0] OP_BCLR = 7'h30;
  localparam logic [OP_W-1:0] OP_BSET = 7'h31;
  localparam logic [OP_W-1:0] OP_BINV = 7'h32;

  localparam logic [SUB_W-1:0] FMOD_SUB = 9'b001101111;

  typedef enum logic [1:0] {
    BK_CLR = 2'd0,
    BK_SET = 2'd1,
    BK_INV = 2'd2
  } bit_kind_e;
endpackage

// File: rtl/fu_truth.sv
module fu_truth
  import flagunit_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              c_old,
  input  logic              z_old,
  output logic              value
);
  always_comb begin
    value = code[{c_old, z_old}];
  end
endmodule

// File: rtl/fu_clamp.sv
module fu_clamp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] d,
  input  logic [DATA_W-1:0] s,
  input  logic              is_signed,
  input  logic              is_ge,
  output logic [DATA_W-1:0] res,
  output logic              replaced,
  output logic              zero
);
  logic d_gt_s;
  logic d_lt_s;

  always_comb begin
    if (is_signed) begin
      d_gt_s = $signed(d) > $signed(s);
      d_lt_s = $signed(d) < $signed(s);
    end else begin
      d_gt_s = d > s;
      d_lt_s = d < s;
    end
    replaced = is_ge ? d_lt_s : d_gt_s;
    res      = replaced ? s : d;
    zero     = (res == '0);
  end
endmodule

// File: rtl/fu_bitop.sv
module fu_bitop
  import flagunit_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] d,
  input  logic [IDX_W-1:0]  idx,
  input  bit_kind_e         kind,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask = '0;
    mask[idx] = 1'b1;
    unique case (kind)
      BK_CLR:  res = d & ~mask;
      BK_SET:  res = d | mask;
      BK_INV:  res = d ^ mask;
      default: res = d;
    endcase
  end
endmodule

// File: rtl/flagunit.sv
module flagunit
  import flagunit_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned INSN_W = 32,
  localparam int unsigned IDX_W = $clog2(DATA_W),
  localparam int unsigned NCODE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_instr,
  input  logic [DATA_W-1:0] in_d,
  input  logic [DATA_W-1:0] in_s,
  input  logic              in_wc,
  input  logic              in_wz,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr,
  output logic              out_c,
  output logic              out_z
);
  // reset release synchroniser
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  // field split
  logic [CODE_W-1:0] f_cond, f_ccode, f_zcode;
  logic [OP_W-1:0]   f_op;
  logic [3:0]        f_rsv;
  logic [SUB_W-1:0]  f_sub;
  assign f_cond  = in_instr[31:28];
  assign f_op    = in_instr[27:21];
  assign f_rsv   = in_instr[20:17];
  assign f_ccode = in_instr[16:13];
  assign f_zcode = in_instr[12:9];
  assign f_sub   = in_instr[8:0];

  // three truth-table evaluators on the old flags: condition, new C, new Z
  logic [CODE_W-1:0] codes [NCODE];
  logic [NCODE-1:0]  tt_val;
  assign codes[0] = f_cond;
  assign codes[1] = f_ccode;
  assign codes[2] = f_zcode;

  for (genvar g = 0; g < NCODE; g++) begin : g_tt
    fu_truth u_tt (
      .code  (codes[g]),
      .c_old (out_c),
      .z_old (out_z),
      .value (tt_val[g])
    );
  end

  logic cond_ok, fm_c, fm_z;
  assign cond_ok = tt_val[0];
  assign fm_c    = tt_val[1];
  assign fm_z    = tt_val[2];

  // clamp datapath
  logic [DATA_W-1:0] cl_res;
  logic              cl_rep, cl_zero;
  fu_clamp #(.DATA_W(DATA_W)) u_clamp (
    .d         (in_d),
    .s         (in_s),
    .is_signed (f_op[0]),
    .is_ge     (f_op[1]),
    .res       (cl_res),
    .replaced  (cl_rep),
    .zero      (cl_zero)
  );

  // bit datapath
  bit_kind_e         bk;
  logic [DATA_W-1:0] bt_res;
  always_comb begin
    unique case (f_op)
      OP_BSET: bk = BK_SET;
      OP_BINV: bk = BK_INV;
      default: bk = BK_CLR;
    endcase
  end

  fu_bitop #(.DATA_W(DATA_W)) u_bit (
    .d    (in_d),
    .idx  (in_s[IDX_W-1:0]),
    .kind (bk),
    .res  (bt_res)
  );

  // next state
  logic              exec;
  logic              fm_hit;
  logic              nxt_c, nxt_z, nxt_wr;
  logic              res_en;
  logic [DATA_W-1:0] nxt_res;

  assign exec   = in_valid && cond_ok;
  assign fm_hit = (f_rsv == '0) && (f_sub == FMOD_SUB);

  always_comb begin
    nxt_c   = out_c;
    nxt_z   = out_z;
    nxt_wr  = 1'b0;
    nxt_res = out_result;
    if (exec) begin
      unique case (f_op)
        OP_FMOD: begin
          if (fm_hit) begin
            if (in_wc) nxt_c = fm_c;
            if (in_wz) nxt_z = fm_z;
          end
        end
        OP_FLEU, OP_FLES, OP_FGEU, OP_FGES: begin
          nxt_wr  = 1'b1;
          nxt_res = cl_res;
          if (in_wc) nxt_c = cl_rep;
          if (in_wz) nxt_z = cl_zero;
        end
        OP_BCLR, OP_BSET, OP_BINV: begin
          nxt_wr  = 1'b1;
          nxt_res = bt_res;
        end
        default: ;
      endcase
    end
  end

  assign res_en = nxt_wr;

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_c  <= 1'b0;
      out_z  <= 1'b0;
      out_wr <= 1'b0;
    end else begin
      out_c  <= nxt_c;
      out_z  <= nxt_z;
      out_wr <= nxt_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_result <= '0;
    end else if (res_en) begin
      out_result <= nxt_res;
    end
  end
endmodule

// File: rtl/fu_chk.sv
module fu_chk
  import flagunit_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              in_valid,
  input logic [3:0]        cond,
  input logic [OP_W-1:0]   op,
  input logic [DATA_W-1:0] in_d,
  input logic [DATA_W-1:0] in_s,
  input logic              in_wc,
  input logic              in_wz,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wr,
  input logic              out_c,
  input logic              out_z
);
  logic cok;
  logic is_bit;
  assign cok    = cond[{out_c, out_z}];
  assign is_bit = (op == OP_BCLR) || (op == OP_BSET) || (op == OP_BINV);

  // R2
  cond_block_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !cok) |=> (!out_wr && out_c == $past(out_c) && out_z == $past(out_z)));

  // R5
  keep_c_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!in_valid || !in_wc) |=> (out_c == $past(out_c)));

  // R5
  keep_z_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!in_valid || !in_wz) |=> (out_z == $past(out_z)));

  // R12
  idle_wr_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!in_valid || (op == OP_FMOD)) |=> !out_wr);

  // R7
  fle_u_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && cok && op == OP_FLEU) |=>
      (out_wr && out_result <= $past(in_s) && out_result <= $past(in_d)));

  // R8
  fge_s_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && cok && op == OP_FGES) |=>
      (out_wr && $signed(out_result) >= $signed($past(in_s))
              && $signed(out_result) >= $signed($past(in_d))));

  // R10
  bit_one_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && cok && is_bit) |=>
      (out_wr && $countones(out_result ^ $past(in_d)) <= 1));

  // R11
  bit_flags_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && is_bit) |=> (out_c == $past(out_c) && out_z == $past(out_z)));
endmodule

bind flagunit fu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_ok),
  .in_valid   (in_valid),
  .cond       (in_instr[31:28]),
  .op         (in_instr[27:21]),
  .in_d       (in_d),
  .in_s       (in_s),
  .in_wc      (in_wc),
  .in_wz      (in_wz),
  .out_result (out_result),
  .out_wr     (out_wr),
  .out_c      (out_c),
  .out_z      (out_z)
);

// File: tb/flagunit_bench.sv
module flagunit_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [6:0] T_FMOD = 7'h12, T_FLEU = 7'h20, T_FLES = 7'h21,
                         T_FGEU = 7'h22, T_FGES = 7'h23,
                         T_BCLR = 7'h30, T_BSET = 7'h31, T_BINV = 7'h32;
  localparam logic [8:0] T_SUB = 9'b001101111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0, in_d = '0, in_s = '0;
  logic        in_wc = 1'b0, in_wz = 1'b0;
  logic [31:0] out_result;
  logic        out_wr, out_c, out_z;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic        mc = 1'b0, mz = 1'b0;
  logic [31:0] mres = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagunit u_flagunit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_d(in_d), .in_s(in_s), .in_wc(in_wc), .in_wz(in_wz),
    .out_result(out_result), .out_wr(out_wr), .out_c(out_c), .out_z(out_z)
  );

  function automatic logic [31:0] mk(input logic [3:0] cnd, input logic [6:0] op,
                                     input logic [3:0] cc, input logic [3:0] zc,
                                     input logic [8:0] sub);
    return {cnd, op, 4'b0000, cc, zc, sub};
  endfunction

  function automatic logic tt(input logic [3:0] code, input logic c, input logic z);
    int i;
    i = (c ? 2 : 0) + (z ? 1 : 0);
    return code[i];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // present one instruction at a falling edge, compare at the next one
  task automatic run(input logic [31:0] ins, input logic [31:0] d, input logic [31:0] s,
                     input logic wc, input logic wz, input logic vld, input string req);
    logic        ewr;
    logic        nc, nz;
    logic [31:0] eres;
    logic [6:0]  op;
    logic        rep;
    int          b;
    ewr = 1'b0; nc = mc; nz = mz; eres = mres; op = ins[27:21];
    if (vld && tt(ins[31:28], mc, mz)) begin
      if (op == T_FMOD) begin
        if (ins[20:17] == 4'd0 && ins[8:0] == T_SUB) begin
          if (wc) nc = tt(ins[16:13], mc, mz);
          if (wz) nz = tt(ins[12:9], mc, mz);
        end
      end else if (op == T_FLEU || op == T_FLES || op == T_FGEU || op == T_FGES) begin
        if (op == T_FLEU)      rep = d > s;
        else if (op == T_FGEU) rep = d < s;
        else if (op == T_FLES) rep = $signed(d) > $signed(s);
        else                   rep = $signed(d) < $signed(s);
        eres = rep ? s : d;
        ewr = 1'b1;
        if (wc) nc = rep;
        if (wz) nz = (eres == 32'd0);
      end else if (op == T_BCLR || op == T_BSET || op == T_BINV) begin
        b = s % 32;
        eres = d;
        if (op == T_BCLR)      eres[b] = 1'b0;
        else if (op == T_BSET) eres[b] = 1'b1;
        else                   eres[b] = ~d[b];
        ewr = 1'b1;
      end
    end
    in_valid = vld; in_instr = ins; in_d = d; in_s = s; in_wc = wc; in_wz = wz;
    @(negedge clk);
    in_valid = 1'b0;
    mc = nc; mz = nz; mres = eres;
    chk(req, "out_wr", {31'd0, out_wr}, {31'd0, ewr});
    chk(req, "out_result", out_result, eres);
    chk(req, "out_c", {31'd0, out_c}, {31'd0, nc});
    chk(req, "out_z", {31'd0, out_z}, {31'd0, nz});
  endtask

  task automatic setf(input logic c, input logic z);
    run(mk(4'hF, T_FMOD, {4{c}}, {4{z}}, T_SUB), 0, 0, 1, 1, 1, "R3");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R0 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk("R1", "out_wr", {31'd0, out_wr}, 32'd0);
    chk("R1", "out_c", {31'd0, out_c}, 32'd0);
    chk("R1", "out_z", {31'd0, out_z}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "out_result", out_result, 32'd0);
    chk("R1", "out_c after release", {31'd0, out_c}, 32'd0);
    run(32'd0, 0, 0, 0, 0, 0, "R1");

    // R3 R4 R6: full sweep of code pairs from all four flag states
    for (int st = 0; st < 4; st++)
      for (int cc = 0; cc < 16; cc++)
        for (int zc = 0; zc < 16; zc++) begin
          setf(st[1], st[0]);
          run(mk(4'hF, T_FMOD, cc[3:0], zc[3:0], T_SUB), 0, 0, 1, 1, 1, "R4");
        end

    // R6: C=0 and Z |= C must see old C
    setf(1, 0);
    run(mk(4'hF, T_FMOD, 4'b0000, 4'b1110, T_SUB), 0, 0, 1, 1, 1, "R6");
    chk("R6", "z uses old c", {31'd0, out_z}, 32'd1);

    // R5: enables
    setf(0, 0);
    run(mk(4'hF, T_FMOD, 4'b1111, 4'b1111, T_SUB), 0, 0, 0, 1, 1, "R5");
    run(mk(4'hF, T_FMOD, 4'b0000, 4'b0000, T_SUB), 0, 0, 1, 0, 1, "R5");

    // R3: wrong sub-opcode and reserved bits do nothing
    setf(0, 0);
    run(mk(4'hF, T_FMOD, 4'hF, 4'hF, 9'b001101110), 0, 0, 1, 1, 1, "R3");
    run(mk(4'hF, T_FMOD, 4'hF, 4'hF, T_SUB) | 32'h0002_0000, 0, 0, 1, 1, 1, "R3");

    // R2: condition false blocks writes; C-only code 1100 with C=0
    setf(0, 1);
    run(mk(4'b1100, T_FLEU, 0, 0, 0), 5, 3, 1, 1, 1, "R2");
    run(mk(4'b1100, T_BSET, 0, 0, 0), 0, 4, 1, 1, 1, "R2");
    run(mk(4'b1100, T_FMOD, 4'hF, 4'h0, T_SUB), 0, 0, 1, 1, 1, "R2");

    // R7 R8 R9 clamps at boundaries
    setf(0, 0);
    run(mk(4'hF, T_FLEU, 0, 0, 0), 32'h8000_0000, 32'h7FFF_FFFF, 1, 1, 1, "R7");
    run(mk(4'hF, T_FLES, 0, 0, 0), 32'h8000_0000, 32'h7FFF_FFFF, 1, 1, 1, "R7");
    run(mk(4'hF, T_FLES, 0, 0, 0), 32'h7FFF_FFFF, 32'h8000_0000, 1, 1, 1, "R7");
    run(mk(4'hF, T_FGEU, 0, 0, 0), 32'h7FFF_FFFF, 32'h8000_0000, 1, 1, 1, "R8");
    run(mk(4'hF, T_FGES, 0, 0, 0), 32'h7FFF_FFFF, 32'h8000_0000, 1, 1, 1, "R8");
    run(mk(4'hF, T_FGES, 0, 0, 0), 32'h8000_0000, 32'h7FFF_FFFF, 1, 1, 1, "R8");
    run(mk(4'hF, T_FLEU, 0, 0, 0), 32'd9, 32'd0, 1, 1, 1, "R9");
    chk("R9", "zero and carry", {30'd0, out_c, out_z}, 32'd3);
    run(mk(4'hF, T_FGEU, 0, 0, 0), 32'd5, 32'd5, 1, 1, 1, "R9");
    run(mk(4'hF, T_FGES, 0, 0, 0), 32'hFFFF_FFFF, 32'd0, 1, 0, 1, "R9");

    // R10 R11 bit operations, index from S[4:0] only
    setf(1, 1);
    run(mk(4'hF, T_BCLR, 0, 0, 0), 32'hFFFF_FFFF, 32'hFFFF_FFE0, 1, 1, 1, "R10");
    run(mk(4'hF, T_BSET, 0, 0, 0), 32'd0, 32'h0000_013F, 1, 1, 1, "R10");
    run(mk(4'hF, T_BINV, 0, 0, 0), 32'h0000_00F0, 32'h0000_0A04, 1, 1, 1, "R11");
    chk("R11", "flags kept", {30'd0, out_c, out_z}, 32'd3);

    // R2: carry-gated bit edits as AND/OR/XOR with C, right after C changes
    for (int cv = 0; cv < 2; cv++) begin
      setf(cv[0], 0);
      run(mk(4'b0011, T_BCLR, 0, 0, 0), 32'hFFFF_FFFF, 32'd7, 0, 0, 1, "R2");
      run(mk(4'b1100, T_BSET, 0, 0, 0), 32'd0, 32'd7, 0, 0, 1, "R2");
      run(mk(4'b1100, T_BINV, 0, 0, 0), 32'd128, 32'd7, 0, 0, 1, "R2");
    end

    // R12: unknown opcode and idle cycles
    run(mk(4'hF, 7'h55, 0, 0, 0), 32'd1, 32'd2, 1, 1, 1, "R12");
    run(mk(4'hF, T_FLEU, 0, 0, 0), 32'd1, 32'd2, 1, 1, 0, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule